// File: doc/BRIEF.md
# Table-Driven State Machine with Condition Select

This block is a finite state machine whose entire behaviour sits in a read-only lookup table. The table is built at elaboration from a parameter that lists transitions. Each clock, the current state code and a small encoded branch code are joined into a table address. The addressed word is latched into one output register. That register holds the next state code, the condition-select field for that state and the machine outputs. It is the state register, so there is no next-state logic apart from the lookup. The table is never written and its read is always enabled. The only enables on the register are reset and hold.

The table sees only a few branch bits, while a controller often has many condition inputs. A multiplexer therefore picks, for each branch bit, one of the condition inputs. The choice comes from a per-state select entry that is stored with the state in the table word. A parameter can replace this multiplexer with a direct connection when there are exactly as many conditions as branch bits. The state code is also a port, so state bits can be used as outputs when the encoding is chosen that way.

Top module: `rom_table_fsm`

## Requirements
- R1: While `rst_i` is high at a rising edge, `state_o` becomes 0 and `out_o` becomes all zeros after that edge.
- R2: The transition list holds row r in bits [r*ROW_W +: ROW_W]. Its fields, from the most significant end, are: current state, branch code, next state, outputs. If a row matches the current state and branch code at a rising edge with reset and hold low, that row's next state and outputs appear after that edge. The table address is {state, branch}, with the branch code in the low bits.
- R3: There is no combinational path from `cond_i` to the outputs. A change of `cond_i` between edges leaves `state_o` and `out_o` unchanged until the next rising edge.
- R4: Branch bit k equals `cond_i[idx_k]`. The select parameter packs one entry per state, with state 0 at the least significant end. Each entry is {idx_1, idx_0}, each index COND index bits wide.
- R5: A (state, branch) pair that no row lists keeps the current state and drives all outputs to zero.
- R6: When several rows list the same (state, branch) pair, the row with the highest index takes effect.
- R7: With `hold_i` high at an edge (and reset low), `state_o` and `out_o` keep their values, whatever `cond_i` is.
- R8: Reset takes priority over hold: reset and hold both high gives state 0 and zero outputs.
- R9: `state_o` shows the state code from the same registered word as `out_o`, and changes at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Freezes the state and output register |
| cond_i | input | COND_W | External condition inputs |
| state_o | output | STATE_W | Current state code |
| out_o | output | OUT_W | Machine outputs from the table word |

## Verification
The bench steps a behavioural model through the same transition list. On every clock it compares both the state and the outputs, under random conditions, random hold and occasional reset. Directed steps cover the following corner cases and the failure each one exposes:
- Per-state selection through several states with different select entries. A crossed index or swapped branch bits would send the machine to the wrong row.
- An unlisted pair. A design without a proper default would jump or leave stale outputs instead of holding the state with outputs low.
- A duplicated row. Taking the first match instead of the last would land on the wrong state.
- Reset and hold high together. This would show hold winning over reset.
- A change of the conditions just before each edge. A combinational leak would make the outputs move early.

// File: rtl/rtfsm_pkg.sv
package rtfsm_pkg;

   // Bits needed to index n items (at least 1).
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((32'd1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/rtfsm_cond_mux.sv
module rtfsm_cond_mux #(
   parameter int unsigned COND_W   = 8,
   parameter int unsigned BR_W     = 2,
   parameter int unsigned IDX_W    = 3,
   parameter bit          USE_CMUX = 1'b1
) (
   input  logic [BR_W*IDX_W-1:0] sel_i,
   input  logic [COND_W-1:0]     cond_i,
   output logic [BR_W-1:0]       br_o
);

   generate
      if (USE_CMUX) begin : g_select
         for (genvar b = 0; b < BR_W; b++) begin : g_bit
            logic [IDX_W-1:0] idx;
            assign idx     = sel_i[b*IDX_W +: IDX_W];
            assign br_o[b] = cond_i[idx];
         end
      end else begin : g_direct
         logic unused_sel;
         assign unused_sel = ^sel_i;
         assign br_o       = cond_i[BR_W-1:0];
      end
   endgenerate

   initial begin
      assert (USE_CMUX || COND_W == BR_W)
         else $error("direct branch wiring needs COND_W == BR_W");
      assert ((32'd1 << IDX_W) >= COND_W)
         else $error("IDX_W too narrow for COND_W");
   end

endmodule

// File: rtl/rtfsm_table.sv
module rtfsm_table #(
   parameter int unsigned STATE_W = 3,
   parameter int unsigned NSTATES = 6,
   parameter int unsigned BR_W    = 2,
   parameter int unsigned OUT_W   = 6,
   parameter int unsigned COND_W  = 8,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned NROWS   = 1,
   parameter int unsigned ROW_W   = 2*STATE_W + BR_W + OUT_W,
   parameter int unsigned SEL_W   = BR_W*IDX_W,
   parameter logic [NROWS*ROW_W-1:0]   TRANS     = '0,
   parameter logic [NSTATES*SEL_W-1:0] STATE_SEL = '0
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      hold_i,
   input  logic [STATE_W+BR_W-1:0]   addr_i,
   output logic [STATE_W-1:0]        state_o,
   output logic [SEL_W-1:0]          sel_o,
   output logic [OUT_W-1:0]          out_o
);

   localparam int unsigned ADDR_W = STATE_W + BR_W;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned WORD_W = STATE_W + SEL_W + OUT_W;
   localparam logic [WORD_W-1:0] RST_WORD = {{STATE_W{1'b0}}, STATE_SEL[SEL_W-1:0], {OUT_W{1'b0}}};

   // Select entry that belongs to a state; 0 for codes outside the used range.
   function automatic logic [SEL_W-1:0] sel_of(input logic [STATE_W-1:0] s);
      logic [SEL_W-1:0] v;
      v = '0;
      if (int'(s) < int'(NSTATES)) v = STATE_SEL[int'(s)*SEL_W +: SEL_W];
      return v;
   endfunction

   // Word for one table address: last matching row wins, else self-loop with zero outputs.
   function automatic logic [WORD_W-1:0] make_word(input int unsigned a);
      logic [STATE_W-1:0] cur, nxt;
      logic [BR_W-1:0]    br;
      logic [OUT_W-1:0]   o;
      logic [ROW_W-1:0]   row;
      cur = STATE_W'(a >> BR_W);
      br  = BR_W'(a);
      nxt = cur;
      o   = '0;
      for (int r = 0; r < int'(NROWS); r++) begin
         row = TRANS[r*ROW_W +: ROW_W];
         if (row[ROW_W-1 -: STATE_W] == cur && row[OUT_W+STATE_W +: BR_W] == br) begin
            nxt = row[OUT_W +: STATE_W];
            o   = row[OUT_W-1:0];
         end
      end
      return {nxt, sel_of(nxt), o};
   endfunction

   logic [WORD_W-1:0] rom [DEPTH];

   generate
      for (genvar a = 0; a < DEPTH; a++) begin : g_word
         localparam logic [WORD_W-1:0] CONTENT = make_word(a);
         assign rom[a] = CONTENT;
      end
   endgenerate

   // Read port always enabled; the latched word is the state register.
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)        word_q <= RST_WORD;
      else if (!hold_i) word_q <= rom[addr_i];
   end

   assign state_o = word_q[WORD_W-1 -: STATE_W];
   assign sel_o   = word_q[OUT_W +: SEL_W];
   assign out_o   = word_q[OUT_W-1:0];

   // Elaboration checks on the transition list and select entries.
   initial begin
      assert (NSTATES <= (32'd1 << STATE_W)) else $error("NSTATES exceeds STATE_W");
      assert (NROWS >= 1) else $error("empty transition list");
      for (int r = 0; r < int'(NROWS); r++) begin
         assert (int'(TRANS[r*ROW_W + OUT_W +: STATE_W]) < int'(NSTATES))
            else $error("row %0d targets an unused state", r);
         assert (int'(TRANS[r*ROW_W + ROW_W - STATE_W +: STATE_W]) < int'(NSTATES))
            else $error("row %0d starts from an unused state", r);
      end
      for (int k = 0; k < int'(NSTATES*BR_W); k++) begin
         assert (int'(STATE_SEL[k*IDX_W +: IDX_W]) < int'(COND_W))
            else $error("select entry %0d out of range", k);
      end
   end

   logic primed_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) primed_q <= 1'b1;
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk_i)
      rst_i |=> (state_o == '0 && out_o == '0));

   // R7
   hold_freezes_chk: assert property (@(posedge clk_i) disable iff (rst_i || !primed_q)
      hold_i |=> ($stable(state_o) && $stable(out_o)));

   // R4
   sel_follows_state_chk: assert property (@(posedge clk_i) disable iff (rst_i || !primed_q)
      sel_o == sel_of(state_o));

   // R2
   state_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i || !primed_q)
      int'(state_o) < int'(NSTATES));

endmodule

// File: rtl/rom_table_fsm.sv
module rom_table_fsm #(
   parameter int unsigned STATE_W  = 3,
   parameter int unsigned NSTATES  = 6,
   parameter int unsigned BR_W     = 2,
   parameter int unsigned OUT_W    = 6,
   parameter int unsigned COND_W   = 8,
   parameter bit          USE_CMUX = 1'b1,
   parameter int unsigned NROWS    = 14,
   parameter logic [NROWS*(2*STATE_W+BR_W+OUT_W)-1:0] TRANS = {
      {3'd1, 2'd0, 3'd3, 6'h33},
      {3'd5, 2'd3, 3'd2, 6'h2A},
      {3'd4, 2'd2, 3'd3, 6'h15},
      {3'd4, 2'd0, 3'd0, 6'h0A},
      {3'd3, 2'd1, 3'd4, 6'h22},
      {3'd2, 2'd3, 3'd5, 6'h11},
      {3'd2, 2'd0, 3'd0, 6'h20},
      {3'd1, 2'd2, 3'd5, 6'h10},
      {3'd1, 2'd1, 3'd4, 6'h08},
      {3'd1, 2'd0, 3'd1, 6'h05},
      {3'd0, 2'd3, 3'd0, 6'h3F},
      {3'd0, 2'd2, 3'd3, 6'h04},
      {3'd0, 2'd1, 3'd2, 6'h02},
      {3'd0, 2'd0, 3'd1, 6'h01}},
   parameter logic [NSTATES*BR_W*rtfsm_pkg::bits_for(COND_W)-1:0] STATE_SEL = {
      3'd2, 3'd5,  3'd0, 3'd7,  3'd7, 3'd6,
      3'd5, 3'd4,  3'd3, 3'd2,  3'd1, 3'd0}
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               hold_i,
   input  logic [COND_W-1:0]  cond_i,
   output logic [STATE_W-1:0] state_o,
   output logic [OUT_W-1:0]   out_o
);

   localparam int unsigned IDX_W = rtfsm_pkg::bits_for(COND_W);
   localparam int unsigned SEL_W = BR_W * IDX_W;
   localparam int unsigned ROW_W = 2*STATE_W + BR_W + OUT_W;

   logic [SEL_W-1:0]        sel;
   logic [BR_W-1:0]         br;
   logic [STATE_W+BR_W-1:0] addr;

   rtfsm_cond_mux #(
      .COND_W   (COND_W),
      .BR_W     (BR_W),
      .IDX_W    (IDX_W),
      .USE_CMUX (USE_CMUX)
   ) u_cmux (
      .sel_i  (sel),
      .cond_i (cond_i),
      .br_o   (br)
   );

   assign addr = {state_o, br};

   rtfsm_table #(
      .STATE_W   (STATE_W),
      .NSTATES   (NSTATES),
      .BR_W      (BR_W),
      .OUT_W     (OUT_W),
      .COND_W    (COND_W),
      .IDX_W     (IDX_W),
      .NROWS     (NROWS),
      .ROW_W     (ROW_W),
      .SEL_W     (SEL_W),
      .TRANS     (TRANS),
      .STATE_SEL (STATE_SEL)
   ) u_table (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .hold_i  (hold_i),
      .addr_i  (addr),
      .state_o (state_o),
      .sel_o   (sel),
      .out_o   (out_o)
   );

endmodule

// File: tb/tb_rom_table_fsm.sv
module tb_rom_table_fsm;

   localparam int SW = 3, NS = 6, BW = 2, OW = 6, CW = 8, NR = 14, IW = 3;
   localparam int RW = 2*SW + BW + OW;

   localparam logic [NR*RW-1:0] LIST = {
      {3'd1, 2'd0, 3'd3, 6'h33},
      {3'd5, 2'd3, 3'd2, 6'h2A},
      {3'd4, 2'd2, 3'd3, 6'h15},
      {3'd4, 2'd0, 3'd0, 6'h0A},
      {3'd3, 2'd1, 3'd4, 6'h22},
      {3'd2, 2'd3, 3'd5, 6'h11},
      {3'd2, 2'd0, 3'd0, 6'h20},
      {3'd1, 2'd2, 3'd5, 6'h10},
      {3'd1, 2'd1, 3'd4, 6'h08},
      {3'd1, 2'd0, 3'd1, 6'h05},
      {3'd0, 2'd3, 3'd0, 6'h3F},
      {3'd0, 2'd2, 3'd3, 6'h04},
      {3'd0, 2'd1, 3'd2, 6'h02},
      {3'd0, 2'd0, 3'd1, 6'h01}};
   localparam logic [NS*BW*IW-1:0] SELS = {
      3'd2, 3'd5,  3'd0, 3'd7,  3'd7, 3'd6,
      3'd5, 3'd4,  3'd3, 3'd2,  3'd1, 3'd0};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst, hold;
   logic [CW-1:0] cond;
   logic [SW-1:0] st;
   logic [OW-1:0] ou;

   rom_table_fsm #(
      .STATE_W(SW), .NSTATES(NS), .BR_W(BW), .OUT_W(OW), .COND_W(CW),
      .USE_CMUX(1'b1), .NROWS(NR), .TRANS(LIST), .STATE_SEL(SELS)
   ) dut (
      .clk_i(clk), .rst_i(rst), .hold_i(hold), .cond_i(cond),
      .state_o(st), .out_o(ou)
   );

   int checks = 0, errors = 0;
   int m_state = 0, m_out = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int branch_of(input int s, input logic [CW-1:0] c);
      int br;
      br = 0;
      for (int b = 0; b < BW; b++) begin
         int idx;
         idx = int'(SELS[(s*BW + b)*IW +: IW]);
         if (c[idx]) br = br | (1 << b);
      end
      return br;
   endfunction

   // One clock: called just after a falling edge.
   task automatic step(input logic r, input logic h, input logic [CW-1:0] c);
      string tag;
      int    br, hits, ns, no;
      // R3: disturbed conditions before the edge must not move the outputs
      rst  = r;
      hold = h;
      cond = ~c;
      #1;
      chk("R3 outputs stable between edges", 32'(ou), 32'(m_out));
      chk("R3 state stable between edges", 32'(st), 32'(m_state));
      cond = c;
      ns = m_state;
      no = m_out;
      if (r) begin
         ns  = 0;
         no  = 0;
         tag = h ? "R8" : "R1";
      end else if (h) begin
         tag = "R7";
      end else begin
         br   = branch_of(m_state, c);
         hits = 0;
         for (int k = 0; k < NR; k++) begin
            logic [RW-1:0] row;
            row = LIST[k*RW +: RW];
            if (int'(row[RW-1 -: SW]) == m_state && int'(row[OW+SW +: BW]) == br) begin
               ns = int'(row[OW +: SW]);
               no = int'(row[OW-1:0]);
               hits++;
            end
         end
         if (hits == 0) begin
            ns  = m_state;
            no  = 0;
            tag = "R5";
         end else begin
            tag = (hits > 1) ? "R6" : "R2";
         end
      end
      m_state = ns;
      m_out   = no;
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R9 state"}, 32'(st), 32'(m_state));
      chk({tag, " outputs"}, 32'(ou), 32'(m_out));
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst  = 1'b1;
      hold = 1'b0;
      cond = '0;
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      step(1'b1, 1'b0, 8'h00);
      chk("R1 reset state", 32'(st), 32'd0);
      chk("R1 reset outputs", 32'(ou), 32'd0);
      // R4 per-state selection through states 0, 2, 5
      step(1'b0, 1'b0, 8'h01);
      chk("R4 state0 picks cond[0]", 32'(st), 32'd2);
      chk("R4 state0 outputs", 32'(ou), 32'h02);
      step(1'b0, 1'b0, 8'h30);
      chk("R4 state2 picks cond[5:4]", 32'(st), 32'd5);
      chk("R4 state2 outputs", 32'(ou), 32'h11);
      step(1'b0, 1'b0, 8'h24);
      chk("R4 state5 picks cond[2],cond[5]", 32'(st), 32'd2);
      chk("R4 state5 outputs", 32'(ou), 32'h2A);
      // R5 unlisted pair
      step(1'b0, 1'b0, 8'h10);
      chk("R5 unlisted keeps state", 32'(st), 32'd2);
      chk("R5 unlisted zero outputs", 32'(ou), 32'd0);
      // R7 hold ignores conditions
      step(1'b0, 1'b0, 8'h30);
      step(1'b0, 1'b1, 8'hFF);
      chk("R7 hold keeps state", 32'(st), 32'd5);
      chk("R7 hold keeps outputs", 32'(ou), 32'h11);
      // R8 reset beats hold
      step(1'b1, 1'b1, 8'hFF);
      chk("R8 reset over hold", 32'(st), 32'd0);
      // R6 duplicated pair, last row wins
      step(1'b0, 1'b0, 8'h00);
      chk("R2 state0 branch0", 32'(st), 32'd1);
      step(1'b0, 1'b0, 8'h00);
      chk("R6 last row wins state", 32'(st), 32'd3);
      chk("R6 last row wins outputs", 32'(ou), 32'h33);
      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic r, h;
         r = ($urandom % 50) == 0;
         h = ($urandom % 5) == 0;
         step(r, h, 8'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule